// File: doc/BRIEF.md
# Precise Exception Tracker for an In-Order Pipeline

This block follows every instruction of a four-register in-order pipeline and decides which instructions may still cause side effects. Fetch, Decode, Execute and Memory can each report a local fault code. The block moves that code along with the instruction's PC through the front, decode, execute and memory pipeline registers. An older code is never overwritten by a later detection. An instruction that carries a nonzero code loses its write permission, so it changes no architectural state.

When a faulting instruction reaches the last register, three things happen in that cycle. Every younger instruction is squashed. The Memory stage is told to perform no access. The fault is committed at the next edge: the return PC, a fault address, the cause and the previous privilege mode are saved, and privileged mode is entered. One cycle after the fault sits in the last register, a redirect pulse carries the handler address. That address comes from a small vector table indexed by the fault code.

Top module: `xcpt_track`

## Requirements
- R1: After reset all four pipeline registers are empty. `stage_live` is 0, `mem_block`, `squash` and `redirect_valid` are 0, `priv_mode` and `prev_mode` are 0, and `epc`, `fault_addr`, `cause` and `redirect_pc` are 0.
- R2: Code value 0 means no fault. Each register takes the code of the instruction entering it. If that code is nonzero it is passed on unchanged; only when it is zero does the local detection code of the stage being left take its place. So the earliest detection wins.
- R3: `stage_live` bit 0 is the front register, bit 1 decode, bit 2 execute and bit 3 memory-to-writeback. A bit is 1 only when its register holds a valid instruction with code 0 and no fault sits in the last register.
- R4: `mem_block` and `squash` are 1 exactly during the cycles in which the last register holds a nonzero code.
- R5: On the edge that ends such a cycle, all four registers are cleared, including the codes of younger instructions. A fetch presented during the redirect cycle is dropped. So only the oldest fault is ever committed.
- R6: Codes 1 (instruction translation miss), 4 (data translation miss) and 5 (misalignment) are retried: `epc` gets the instruction's PC. All other nonzero codes, such as 2 (illegal) and 3 (trap), are skipped: `epc` gets PC+1, modulo 2^16.
- R7: `fault_addr` gets the address that was on `ex_alu_addr` while the instruction was in Execute when the code is 4. For any other code it gets the instruction's PC.
- R8: `redirect_valid` is 1 for exactly the one cycle after the fault cycle. In that cycle `redirect_pc` = VEC_BASE + code*VEC_STEP (0xFF00 + code*0x10 by default) and `cause` equals the code.
- R9: On the commit edge `priv_mode` becomes 1 and `prev_mode` takes the old `priv_mode`, in the same edge as `epc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | An instruction is being fetched this cycle |
| fetch_pc | input | 16 | PC of the instruction being fetched |
| det_if | input | 3 | Fault code detected in Fetch (0 = none) |
| det_id | input | 3 | Fault code detected in Decode |
| det_ex | input | 3 | Fault code detected in Execute |
| det_mem | input | 3 | Fault code detected in Memory |
| ex_alu_addr | input | 16 | ALU address of the instruction in Execute |
| stage_live | output | 4 | Per-register side-effect permission |
| mem_block | output | 1 | Memory stage must not read or write |
| squash | output | 1 | Fault at writeback; younger instructions are killed |
| redirect_valid | output | 1 | Next PC must be taken from redirect_pc |
| redirect_pc | output | 16 | Handler address from the vector table |
| epc | output | 16 | Saved return PC |
| fault_addr | output | 16 | Saved faulting address |
| cause | output | 3 | Saved fault code |
| priv_mode | output | 1 | Current mode, 1 = privileged |
| prev_mode | output | 1 | Mode held before the last fault |

## Verification
The bench builds the block with its default parameters: a 16-bit PC, 3-bit codes, vector base 0xFF00 with stride 0x10, and retry mask 0b00110010. With these values every code has its own vector. A trap at PC 0xFFFF shows whether the skipped return address wraps to 0. Faults are injected at each of the four stages. One instruction is given two detections to show that the earlier one wins. A burst of younger faulting instructions, plus a fetch in the redirect cycle, shows that only the oldest fault commits.

// File: rtl/xt_pkg.sv
// Package: fault code values shared by the tracker and its users.
// Assumes a code of zero means "no fault".
package xt_pkg;
    localparam int unsigned XC_NONE    = 0;
    localparam int unsigned XC_ITLB    = 1;
    localparam int unsigned XC_ILLEGAL = 2;
    localparam int unsigned XC_TRAP    = 3;
    localparam int unsigned XC_DTLB    = 4;
    localparam int unsigned XC_ALIGN   = 5;
    // Default retry set: instruction miss, data miss, misalignment.
    localparam logic [7:0] XC_RETRY_DEFAULT = 8'b0011_0010;
endpackage

// File: rtl/xt_slot.sv
// Module: one pipeline register slot carrying valid, PC and fault code.
// Loads every cycle (no stalls). An incoming nonzero code is kept;
// otherwise the local detection code is taken. Flush empties the slot.
module xt_slot #(
    parameter int PC_W   = 16,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [CODE_W-1:0] in_code,
    input  logic [CODE_W-1:0] det_code,
    output logic [CODE_W-1:0] nxt_code,
    output logic              out_valid,
    output logic [PC_W-1:0]   out_pc,
    output logic [CODE_W-1:0] out_code
);

    // Merge: the older code has priority over this stage's detection.
    always_comb begin
        if (!in_valid)
            nxt_code = '0;
        else if (in_code != '0)
            nxt_code = in_code;
        else
            nxt_code = det_code;
    end

    // Slot register update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            out_valid <= 1'b0;
            out_pc    <= '0;
            out_code  <= '0;
        end else begin
            out_valid <= in_valid;
            out_pc    <= in_pc;
            out_code  <= nxt_code;
        end
    end

    // R2
    code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_code != '0 && !flush) |=> (out_code == $past(in_code)));

endmodule

// File: rtl/xt_vecrom.sv
// Module: vector table, one handler address per fault code, read
// synchronously. Entries are computed from base and stride.
module xt_vecrom #(
    parameter int              PC_W     = 16,
    parameter int              CODE_W   = 3,
    parameter logic [PC_W-1:0] VEC_BASE = 16'hFF00,
    parameter logic [PC_W-1:0] VEC_STEP = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [CODE_W-1:0] rd_code,
    output logic [PC_W-1:0]   rd_addr
);
    localparam int DEPTH = 2 ** CODE_W;

    logic [PC_W-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = PC_W'(VEC_BASE + VEC_STEP * PC_W'(i));
    end

    // Registered read of the handler address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_addr <= '0;
        else if (rd_en)
            rd_addr <= table_q[rd_code];
    end
endmodule

// File: rtl/xt_commit.sv
// Module: commit state written when a fault is taken at writeback.
// Saves the return PC (retry or skip), fault address, cause and modes
// in one edge and raises a one-cycle redirect flag.
module xt_commit #(
    parameter int                     PC_W       = 16,
    parameter int                     CODE_W     = 3,
    parameter logic [2**CODE_W-1:0]   RETRY_MASK = 8'b0011_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [PC_W-1:0]   wb_pc,
    input  logic [CODE_W-1:0] wb_code,
    input  logic [PC_W-1:0]   wb_fault,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   epc,
    output logic [PC_W-1:0]   fault_addr,
    output logic [CODE_W-1:0] cause,
    output logic              priv_mode,
    output logic              prev_mode
);

    // Atomic update of all commit state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            epc            <= '0;
            fault_addr     <= '0;
            cause          <= '0;
            priv_mode      <= 1'b0;
            prev_mode      <= 1'b0;
        end else begin
            redirect_valid <= take;
            if (take) begin
                epc        <= RETRY_MASK[wb_code] ? wb_pc : wb_pc + PC_W'(1);
                fault_addr <= wb_fault;
                cause      <= wb_code;
                priv_mode  <= 1'b1;
                prev_mode  <= priv_mode;
            end
        end
    end

    // R6
    epc_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (epc == $past(wb_pc) || epc == $past(wb_pc) + PC_W'(1)));

    // R9
    priv_on_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> priv_mode);

endmodule

// File: rtl/xcpt_track.sv
// Module: precise fault tracker for a four-register in-order pipeline.
// Assumes the pipeline advances every cycle. Slot 0 is the front register,
// slot 3 is memory-to-writeback. A nonzero code in slot 3 squashes all
// younger work, blocks memory and commits the fault at the next edge.
module xcpt_track #(
    parameter int                   PC_W       = 16,
    parameter int                   CODE_W     = 3,
    parameter logic [PC_W-1:0]      VEC_BASE   = 16'hFF00,
    parameter logic [PC_W-1:0]      VEC_STEP   = 16'h0010,
    parameter logic [2**CODE_W-1:0] RETRY_MASK = xt_pkg::XC_RETRY_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic [CODE_W-1:0] det_if,
    input  logic [CODE_W-1:0] det_id,
    input  logic [CODE_W-1:0] det_ex,
    input  logic [CODE_W-1:0] det_mem,
    input  logic [PC_W-1:0]   ex_alu_addr,
    output logic [3:0]        stage_live,
    output logic              mem_block,
    output logic              squash,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc,
    output logic [PC_W-1:0]   epc,
    output logic [PC_W-1:0]   fault_addr,
    output logic [CODE_W-1:0] cause,
    output logic              priv_mode,
    output logic              prev_mode
);
    localparam int NSLOT = 4;
    localparam logic [CODE_W-1:0] DTLB_CODE = CODE_W'(xt_pkg::XC_DTLB);

    logic              c_valid [NSLOT+1];
    logic [PC_W-1:0]   c_pc    [NSLOT+1];
    logic [CODE_W-1:0] c_code  [NSLOT+1];
    logic [CODE_W-1:0] det     [NSLOT];
    logic [CODE_W-1:0] nxt     [NSLOT];
    logic              wb_exc;
    logic [PC_W-1:0]   exmem_alu;
    logic [PC_W-1:0]   memwb_fault;

    assign wb_exc = c_valid[NSLOT] && (c_code[NSLOT] != '0);

    // A fetch arriving during the redirect cycle is wrong-path: drop it.
    assign c_valid[0] = fetch_valid && !redirect_valid;
    assign c_pc[0]    = fetch_pc;
    assign c_code[0]  = '0;
    assign det[0] = det_if;
    assign det[1] = det_id;
    assign det[2] = det_ex;
    assign det[3] = det_mem;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        xt_slot #(.PC_W(PC_W), .CODE_W(CODE_W)) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (wb_exc),
            .in_valid (c_valid[s]),
            .in_pc    (c_pc[s]),
            .in_code  (c_code[s]),
            .det_code (det[s]),
            .nxt_code (nxt[s]),
            .out_valid(c_valid[s+1]),
            .out_pc   (c_pc[s+1]),
            .out_code (c_code[s+1])
        );
        assign stage_live[s] = c_valid[s+1] && (c_code[s+1] == '0) && !wb_exc;
    end

    // Side registers: ALU address in EX/MEM, fault address in MEM/WB.
    always_ff @(posedge clk) begin
        if (!rst_n || wb_exc) begin
            exmem_alu   <= '0;
            memwb_fault <= '0;
        end else begin
            exmem_alu   <= ex_alu_addr;
            memwb_fault <= (nxt[3] == DTLB_CODE) ? exmem_alu : c_pc[3];
        end
    end

    assign mem_block = wb_exc;
    assign squash    = wb_exc;

    xt_vecrom #(
        .PC_W(PC_W), .CODE_W(CODE_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) i_vecrom (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (wb_exc),
        .rd_code(c_code[NSLOT]),
        .rd_addr(redirect_pc)
    );

    xt_commit #(
        .PC_W(PC_W), .CODE_W(CODE_W), .RETRY_MASK(RETRY_MASK)
    ) i_commit (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (wb_exc),
        .wb_pc         (c_pc[NSLOT]),
        .wb_code       (c_code[NSLOT]),
        .wb_fault      (memwb_fault),
        .redirect_valid(redirect_valid),
        .epc           (epc),
        .fault_addr    (fault_addr),
        .cause         (cause),
        .priv_mode     (priv_mode),
        .prev_mode     (prev_mode)
    );

    // R8
    redirect_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> redirect_valid);

    // R8
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    // R5
    squash_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (stage_live == 4'b0000 && !mem_block));

endmodule

// File: tb/test_xcpt_track.sv
// Bench: a scoreboard of expected commits is filled by the driver and
// emptied by a monitor that watches for redirect pulses.
module test_xcpt_track;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] epc;
        logic [15:0] fault;
        logic [15:0] vec;
        logic [2:0]  cause;
        logic        prev;
    } commit_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic [2:0]  det_if = '0, det_id = '0, det_ex = '0, det_mem = '0;
    logic [15:0] ex_alu_addr = '0;
    logic [3:0]  stage_live;
    logic        mem_block, squash, redirect_valid, priv_mode, prev_mode;
    logic [15:0] redirect_pc, epc, fault_addr;
    logic [2:0]  cause;

    int checks = 0;
    int failures = 0;
    commit_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xcpt_track i_xcpt_track (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .det_if(det_if), .det_id(det_id), .det_ex(det_ex), .det_mem(det_mem),
        .ex_alu_addr(ex_alu_addr), .stage_live(stage_live), .mem_block(mem_block),
        .squash(squash), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .epc(epc), .fault_addr(fault_addr), .cause(cause),
        .priv_mode(priv_mode), .prev_mode(prev_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] vec_of(input logic [2:0] c);
        return 16'hFF00 + 16'(c) * 16'h0010;
    endfunction

    task automatic expect_commit(input logic [15:0] e, input logic [15:0] f,
                                 input logic [2:0] c, input logic p);
        commit_t it;
        it.epc = e; it.fault = f; it.vec = vec_of(c); it.cause = c; it.prev = p;
        exp_q.push_back(it);
    endtask

    // One cycle: drive inputs at a falling edge, return at the next one.
    task automatic step(input logic fv, input logic [15:0] pc, input logic [2:0] dif,
                        input logic [2:0] did, input logic [2:0] dex,
                        input logic [2:0] dmem, input logic [15:0] alu);
        fetch_valid = fv; fetch_pc = pc; det_if = dif; det_id = did;
        det_ex = dex; det_mem = dmem; ex_alu_addr = alu;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
    endtask

    // Monitor: every redirect pulse must match the oldest expected commit.
    always @(negedge clk) begin
        if (rst_n && redirect_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R5 unexpected redirect actual epc=%h expected none", epc);
            end else begin
                commit_t it;
                it = exp_q.pop_front();
                chk("R6 epc", 32'(epc), 32'(it.epc));
                chk("R7 fault_addr", 32'(fault_addr), 32'(it.fault));
                chk("R8 redirect_pc", 32'(redirect_pc), 32'(it.vec));
                chk("R8 cause", 32'(cause), 32'(it.cause));
                chk("R9 priv_mode", 32'(priv_mode), 32'd1);
                chk("R9 prev_mode", 32'(prev_mode), 32'(it.prev));
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 stage_live", 32'(stage_live), 32'd0);
        chk("R1 mem_block", 32'(mem_block), 32'd0);
        chk("R1 redirect_valid", 32'(redirect_valid), 32'd0);
        chk("R1 priv_mode", 32'(priv_mode), 32'd0);
        chk("R1 epc", 32'(epc), 32'd0);
        chk("R1 redirect_pc", 32'(redirect_pc), 32'd0);

        // R3: clean instruction walks through the live bits
        step(1'b1, 16'h0500, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        chk("R3 live front", 32'(stage_live), 32'h1);
        step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        chk("R3 live decode", 32'(stage_live), 32'h2);
        step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        chk("R3 live execute", 32'(stage_live), 32'h4);
        step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        chk("R3 live writeback", 32'(stage_live), 32'h8);
        chk("R4 no block when clean", 32'(mem_block), 32'd0);
        idle(2);
        chk("R8 no redirect for clean", 32'(redirect_valid), 32'd0);

        // R6 retry: instruction miss in Fetch at 0x0100
        expect_commit(16'h0100, 16'h0100, 3'd1, 1'b0);
        step(1'b1, 16'h0100, 3'd1, 3'd0, 3'd0, 3'd0, 16'h0);
        chk("R3 faulting front not live", 32'(stage_live), 32'h0);
        idle(3);
        chk("R4 mem_block", 32'(mem_block), 32'd1);
        chk("R4 squash", 32'(squash), 32'd1);
        idle(1);
        chk("R8 redirect pulse", 32'(redirect_valid), 32'd1);
        idle(1);
        chk("R8 pulse ends", 32'(redirect_valid), 32'd0);
        chk("R4 block ends", 32'(mem_block), 32'd0);

        // R7 data miss in Memory uses the ALU address
        expect_commit(16'h0200, 16'hBEEF, 3'd4, 1'b1);
        step(1'b1, 16'h0200, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd0, 16'hBEEF);
        step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd4, 16'h0);
        idle(3);

        // R2 priority: trap in Decode beats data miss in Memory
        expect_commit(16'h0301, 16'h0300, 3'd3, 1'b1);
        step(1'b1, 16'h0300, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        step(1'b0, 16'h0, 3'd0, 3'd3, 3'd0, 3'd0, 16'h0);
        step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd0, 16'h1234);
        step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd4, 16'h0);
        idle(3);

        // R5 squash: misalignment in Execute at 0x0400, younger ones faulting
        expect_commit(16'h0400, 16'h0400, 3'd5, 1'b1);
        step(1'b1, 16'h0400, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        step(1'b1, 16'h0401, 3'd1, 3'd0, 3'd0, 3'd0, 16'h0);
        step(1'b1, 16'h0402, 3'd0, 3'd0, 3'd5, 3'd0, 16'h0);
        step(1'b1, 16'h0403, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        chk("R5 all killed during fault", 32'(stage_live), 32'h0);
        chk("R4 mem_block squash", 32'(mem_block), 32'd1);
        step(1'b1, 16'h0404, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        chk("R5 registers emptied", 32'(stage_live), 32'h0);
        chk("R5 no fault left", 32'(mem_block), 32'd0);
        step(1'b1, 16'h0405, 3'd1, 3'd0, 3'd0, 3'd0, 16'h0);
        chk("R5 redirect-cycle fetch dropped", 32'(stage_live), 32'h0);
        idle(6);
        chk("R5 younger fault never taken", 32'(exp_q.size()), 32'd0);

        // R6 skip: illegal detected in Memory
        expect_commit(16'h0601, 16'h0600, 3'd2, 1'b1);
        step(1'b1, 16'h0600, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0);
        step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd0, 16'h5555);
        step(1'b0, 16'h0, 3'd0, 3'd0, 3'd0, 3'd2, 16'h0);
        idle(3);

        // R6 wrap: trap at 0xFFFF returns to 0x0000
        expect_commit(16'h0000, 16'hFFFF, 3'd3, 1'b1);
        step(1'b1, 16'hFFFF, 3'd3, 3'd0, 3'd0, 3'd0, 16'h0);
        idle(6);

        chk("R8 every expected redirect seen", 32'(exp_q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule